// File: doc/BRIEF.md
# Two-Channel Current-DAC Control Slave on I2C

This block sits between a two-wire serial bus and two bidirectional current-DAC channels. A fast system clock samples the bus clock and data lines. It detects start, repeated-start and stop conditions and answers a fixed 7-bit device address. It keeps one 8-bit control register for each channel. Each register holds a sign-magnitude code. The sign selects whether the channel sources or sinks current. The 7-bit magnitude sets the step, and a magnitude of zero means no current whatever the sign.

A controller writes a register by sending the device address with the write flag, then a register address byte, then a data byte. To read, it sets the register address the same way, issues a repeated start, sends the device address with the read flag, and clocks out one byte. It ends the read with a not-acknowledge. The register address persists between transactions, so a later read with no address phase returns the last selected register. The slave drives the data line open-drain: it has only an enable that pulls the line low. It makes every change to that enable while the bus clock is low.

Top module: `dac_ctl_i2c_slave`

## Requirements
- R1: After reset both control registers are 00h, every channel reports sign 0, magnitude 0 and enable 0, and the slave does not pull the data line.
- R2: The slave acknowledges the address bytes 90h (write) and 91h (read) by pulling the data line low in the ninth bit. Any other address byte is not acknowledged, and all later bytes are ignored and not acknowledged until the next start.
- R3: Writing register F8h sets channel 0 and writing F9h sets channel 1. Bit 7 of the data becomes the channel's source flag (1 = source, 0 = sink) and bits 6:0 become its magnitude. Register and magnitude outputs change only while the filtered bus clock is low.
- R4: A channel's enable output is 1 exactly when its magnitude is nonzero. Code 80h therefore gives enable 0 with the source flag set.
- R5: A read returns the selected register MSB first, one bit per clock. After the controller's not-acknowledge the slave no longer pulls the data line.
- R6: A register address other than F8h or F9h is acknowledged. Data written to it changes no channel, and a read from it returns 00h.
- R7: A repeated start or a stop that arrives before the eighth data bit has been clocked aborts the transfer, and both registers keep their values.
- R8: The slave changes its pull-down enable only while the filtered bus clock is low, so it holds the enable constant through every clock-high phase.
- R9: The selected register address persists after a stop. A read transaction that carries only the read address byte returns the register chosen by the last address write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | Pull-down enable for the data line (output value is 0) |
| src_o | output | NCH | Per-channel source flag (1 source, 0 sink) |
| mag_o | output | NCH*MAG_W | Per-channel magnitude, channel i at bits i*MAG_W upward |
| en_o | output | NCH | Per-channel output enable, high for nonzero magnitude |

## Verification
The checker enforces the cycle-level rules on every cycle. These are: the zero state during reset; changes to the pull-down enable and to the magnitudes happening only while the filtered clock is low; the enable never toggling without a magnitude change; and no register change right after a stop. Whether the slave answers the right addresses, decodes the sign-magnitude code, drops out after a wrong address, keeps the register address between transactions and throws away aborted bytes can only be shown by whole bus transactions in the bench.

// File: rtl/dacctl_pkg.sv
package dacctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK
    } bus_st_e;

    typedef enum logic [1:0] {
        K_DEV,
        K_MEM,
        K_DATA
    } byte_kind_e;

    typedef struct packed {
        bus_st_e    st;
        byte_kind_e kind;
        logic [3:0] bitcnt;
        logic [7:0] shreg;
        logic [7:0] ptr;
        logic       rd;
        logic       rose;
        logic       oe;
        logic       wr;
        logic       scl_p;
        logic       sda_p;
    } fsm_s;

    localparam fsm_s FSM_RST = '{
        st: ST_IDLE, kind: K_DEV, bitcnt: 4'd0, shreg: 8'h00, ptr: 8'h00,
        rd: 1'b0, rose: 1'b0, oe: 1'b0, wr: 1'b0, scl_p: 1'b1, sda_p: 1'b1
    };

endpackage

// File: rtl/dac_ctl_line_filt.sv
module dac_ctl_line_filt #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic [CW-1:0] cnt;
        logic          filt;
    } filt_s;

    filt_s flt_d, flt_q;

    always_comb begin
        flt_d      = flt_q;
        flt_d.sync = {flt_q.sync[0], line_i};
        if (flt_q.sync[1] == flt_q.filt) begin
            flt_d.cnt = '0;
        end else if (flt_q.cnt == CW'(FILT_LEN - 1)) begin
            flt_d.filt = flt_q.sync[1];
            flt_d.cnt  = '0;
        end else begin
            flt_d.cnt = flt_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flt_q <= '{sync: 2'b11, cnt: '0, filt: 1'b1};
        else        flt_q <= flt_d;
    end

    assign line_o = flt_q.filt;
endmodule

// File: rtl/dac_ctl_bus_fsm.sv
module dac_ctl_bus_fsm
    import dacctl_pkg::*;
#(
    parameter logic [6:0] SLV_ADDR = 7'h48
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_f,
    input  logic       sda_f,
    input  logic [7:0] rdata_i,
    output logic       sda_oe_o,
    output logic       wr_o,
    output logic [7:0] wr_addr_o,
    output logic [7:0] wr_data_o,
    output logic       stop_o
);
    fsm_s fsm_d, fsm_q;
    logic scl_rise, scl_fall, start_e, stop_e;

    always_comb begin
        scl_rise = scl_f & ~fsm_q.scl_p;
        scl_fall = ~scl_f & fsm_q.scl_p;
        start_e  = fsm_q.scl_p & scl_f & fsm_q.sda_p & ~sda_f;
        stop_e   = fsm_q.scl_p & scl_f & ~fsm_q.sda_p & sda_f;

        fsm_d       = fsm_q;
        fsm_d.wr    = 1'b0;
        fsm_d.scl_p = scl_f;
        fsm_d.sda_p = sda_f;

        if (start_e) begin
            fsm_d.st     = ST_RX;
            fsm_d.kind   = K_DEV;
            fsm_d.bitcnt = 4'd0;
            fsm_d.oe     = 1'b0;
            fsm_d.rose   = 1'b0;
        end else if (stop_e) begin
            fsm_d.st = ST_IDLE;
            fsm_d.oe = 1'b0;
        end else begin
            case (fsm_q.st)
                ST_RX: begin
                    if (scl_rise && fsm_q.bitcnt < 4'd8) begin
                        fsm_d.shreg  = {fsm_q.shreg[6:0], sda_f};
                        fsm_d.bitcnt = fsm_q.bitcnt + 4'd1;
                    end else if (scl_fall && fsm_q.bitcnt == 4'd8) begin
                        fsm_d.st   = ST_ACK;
                        fsm_d.oe   = 1'b1;
                        fsm_d.rose = 1'b0;
                        case (fsm_q.kind)
                            K_DEV: begin
                                if (fsm_q.shreg[7:1] == SLV_ADDR) begin
                                    fsm_d.rd = fsm_q.shreg[0];
                                end else begin
                                    fsm_d.st = ST_IDLE;
                                    fsm_d.oe = 1'b0;
                                end
                            end
                            K_MEM:   fsm_d.ptr = fsm_q.shreg;
                            default: fsm_d.wr  = 1'b1;
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_rise) begin
                        fsm_d.rose = 1'b1;
                    end else if (scl_fall && fsm_q.rose) begin
                        fsm_d.rose   = 1'b0;
                        fsm_d.bitcnt = 4'd0;
                        if (fsm_q.rd) begin
                            fsm_d.st    = ST_TX;
                            fsm_d.shreg = rdata_i;
                            fsm_d.oe    = ~rdata_i[7];
                        end else begin
                            fsm_d.st   = ST_RX;
                            fsm_d.oe   = 1'b0;
                            fsm_d.kind = (fsm_q.kind == K_DEV) ? K_MEM : K_DATA;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        fsm_d.bitcnt = fsm_q.bitcnt + 4'd1;
                    end else if (scl_fall) begin
                        if (fsm_q.bitcnt == 4'd8) begin
                            fsm_d.oe   = 1'b0;
                            fsm_d.st   = ST_MACK;
                            fsm_d.rose = 1'b0;
                        end else begin
                            fsm_d.shreg = {fsm_q.shreg[6:0], 1'b0};
                            fsm_d.oe    = ~fsm_q.shreg[6];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        if (sda_f) fsm_d.st   = ST_IDLE;
                        else       fsm_d.rose = 1'b1;
                    end else if (scl_fall && fsm_q.rose) begin
                        fsm_d.rose   = 1'b0;
                        fsm_d.bitcnt = 4'd0;
                        fsm_d.st     = ST_TX;
                        fsm_d.shreg  = rdata_i;
                        fsm_d.oe     = ~rdata_i[7];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= FSM_RST;
        else        fsm_q <= fsm_d;
    end

    assign sda_oe_o  = fsm_q.oe;
    assign wr_o      = fsm_q.wr;
    assign wr_addr_o = fsm_q.ptr;
    assign wr_data_o = fsm_q.shreg;
    assign stop_o    = stop_e;
endmodule

// File: rtl/dac_ctl_regs.sv
module dac_ctl_regs #(
    parameter int         NCH       = 2,
    parameter int         MAG_W     = 7,
    parameter logic [7:0] BASE_ADDR = 8'hF8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_i,
    input  logic [7:0]           addr_i,
    input  logic [7:0]           wdata_i,
    output logic [7:0]           rdata_o,
    output logic [NCH-1:0]       src_o,
    output logic [NCH*MAG_W-1:0] mag_o,
    output logic [NCH-1:0]       en_o
);
    localparam int REG_W = MAG_W + 1;

    logic [NCH-1:0][REG_W-1:0] regs_d, regs_q;

    always_comb begin
        regs_d  = regs_q;
        rdata_o = 8'h00;
        for (int i = 0; i < NCH; i++) begin
            if (addr_i == 8'(BASE_ADDR + i)) begin
                rdata_o = 8'(regs_q[i]);
                if (wr_i) regs_d[i] = wdata_i[REG_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign src_o[g]                 = regs_q[g][REG_W-1];
        assign mag_o[g*MAG_W +: MAG_W]  = regs_q[g][MAG_W-1:0];
        assign en_o[g]                  = |regs_q[g][MAG_W-1:0];
    end
endmodule

// File: rtl/dac_ctl_i2c_slave.sv
module dac_ctl_i2c_slave #(
    parameter int         NCH       = 2,
    parameter int         MAG_W     = 7,
    parameter int         FILT_LEN  = 4,
    parameter logic [6:0] SLV_ADDR  = 7'h48,
    parameter logic [7:0] BASE_ADDR = 8'hF8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_i,
    input  logic                 sda_i,
    output logic                 sda_oe_o,
    output logic [NCH-1:0]       src_o,
    output logic [NCH*MAG_W-1:0] mag_o,
    output logic [NCH-1:0]       en_o
);
    logic       scl_flt, sda_flt, stop_evt, wr;
    logic [7:0] wr_addr, wr_data, rdata;

    dac_ctl_line_filt #(.FILT_LEN(FILT_LEN)) scl_filt_i (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i), .line_o(scl_flt)
    );

    dac_ctl_line_filt #(.FILT_LEN(FILT_LEN)) sda_filt_i (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i), .line_o(sda_flt)
    );

    dac_ctl_bus_fsm #(.SLV_ADDR(SLV_ADDR)) fsm_i (
        .clk(clk), .rst_n(rst_n), .scl_f(scl_flt), .sda_f(sda_flt),
        .rdata_i(rdata), .sda_oe_o(sda_oe_o), .wr_o(wr),
        .wr_addr_o(wr_addr), .wr_data_o(wr_data), .stop_o(stop_evt)
    );

    dac_ctl_regs #(.NCH(NCH), .MAG_W(MAG_W), .BASE_ADDR(BASE_ADDR)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_i(wr), .addr_i(wr_addr),
        .wdata_i(wr_data), .rdata_o(rdata), .src_o(src_o),
        .mag_o(mag_o), .en_o(en_o)
    );
endmodule

// File: rtl/dac_ctl_chk.sv
module dac_ctl_chk #(
    parameter int NCH   = 2,
    parameter int MAG_W = 7
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 scl_flt,
    input logic                 stop_evt,
    input logic                 sda_oe_o,
    input logic [NCH-1:0]       src_o,
    input logic [NCH-1:0]       en_o,
    input logic [NCH*MAG_W-1:0] mag_o
);
    logic in_rst_q;

    always_ff @(posedge clk) in_rst_q <= !rst_n;

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        in_rst_q |-> (mag_o == '0 && src_o == '0 && en_o == '0 && !sda_oe_o));

    // R8
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_flt);

    // R3
    mag_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mag_o) |-> !scl_flt);

    // R4
    en_follows_mag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(en_o) |-> !$stable(mag_o));

    // R7
    stop_keeps_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> ($stable(mag_o) && $stable(src_o)));
endmodule

bind dac_ctl_i2c_slave dac_ctl_chk #(.NCH(NCH), .MAG_W(MAG_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .scl_flt(scl_flt), .stop_evt(stop_evt),
    .sda_oe_o(sda_oe_o), .src_o(src_o), .en_o(en_o), .mag_o(mag_o)
);

// File: tb/dac_ctl_i2c_slave_tb.sv
module dac_ctl_i2c_slave_tb_top;
    localparam int NCH = 2;
    localparam int MW  = 7;
    localparam int Q   = 20;

    // {mem addr, data, exp src, exp mag, exp en} for the addressed channel
    localparam int NV = 7;
    localparam logic [24:0] VEC [NV] = '{
        {8'hF8, 8'hAA, 1'b1, 7'h2A, 1'b1},
        {8'hF9, 8'h15, 1'b0, 7'h15, 1'b1},
        {8'hF8, 8'h80, 1'b1, 7'h00, 1'b0},
        {8'hF9, 8'hFF, 1'b1, 7'h7F, 1'b1},
        {8'hF9, 8'h00, 1'b0, 7'h00, 1'b0},
        {8'hF8, 8'h7F, 1'b0, 7'h7F, 1'b1},
        {8'hF8, 8'h01, 1'b0, 7'h01, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;
    logic [NCH-1:0]    src;
    logic [NCH*MW-1:0] mag;
    logic [NCH-1:0]    en;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] shadow [NCH];
    logic last_oe;

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    dac_ctl_i2c_slave dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .src_o(src), .mag_o(mag), .en_o(en)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bit_cycle(input logic b, output logic mid, output logic o0, output logic o1);
        sda_m = b;
        tick(Q);
        scl_m = 1'b1;
        tick(1);
        o0 = sda_oe;
        tick(Q - 1);
        mid = sda_line;
        tick(Q - 1);
        o1 = sda_oe;
        tick(1);
        scl_m = 1'b0;
        tick(Q);
    endtask

    task automatic bus_start();
        sda_m = 1'b1;
        tick(Q);
        scl_m = 1'b1;
        tick(Q);
        sda_m = 1'b0;
        tick(Q);
        scl_m = 1'b0;
        tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0;
        tick(Q);
        scl_m = 1'b1;
        tick(Q);
        sda_m = 1'b1;
        tick(2 * Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic m, o0, o1;
        for (int i = 7; i >= 0; i--) bit_cycle(b[i], m, o0, o1);
        bit_cycle(1'b1, m, o0, o1);
        ack = !m;
        // R8: pull-down held across the clock-high phase of the ack bit
        if (ack) chk("R8 oe steady in ack high", int'(o1), int'(o0));
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] d);
        logic m, o0, o1;
        for (int i = 7; i >= 0; i--) begin
            bit_cycle(1'b1, m, o0, o1);
            d[i] = m;
        end
        bit_cycle(nack, m, o0, o1);
        last_oe = o1;
    endtask

    task automatic write_txn(input logic [7:0] mem, input logic [7:0] data, output logic [2:0] acks);
        bus_start();
        send_byte(8'h90, acks[2]);
        send_byte(mem, acks[1]);
        send_byte(data, acks[0]);
        bus_stop();
    endtask

    task automatic read_txn(input logic [7:0] mem, output logic [7:0] d, output logic [2:0] acks);
        bus_start();
        send_byte(8'h90, acks[2]);
        send_byte(mem, acks[1]);
        bus_start();
        send_byte(8'h91, acks[0]);
        recv_byte(1'b1, d);
        bus_stop();
    endtask

    task automatic check_channels(input string tag);
        for (int c = 0; c < NCH; c++) begin
            chk({tag, " R3 src"}, int'(src[c]), int'(shadow[c][7]));
            chk({tag, " R3 mag"}, int'(mag[c*MW +: MW]), int'(shadow[c][6:0]));
            chk({tag, " R4 en"}, int'(en[c]), int'(shadow[c][6:0] != 7'd0));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [2:0] acks;
        logic [7:0] rd;
        logic a;
        shadow[0] = 8'h00;
        shadow[1] = 8'h00;

        tick(10);
        // R1: reset state
        chk("R1 src", int'(src), 0);
        chk("R1 mag", int'(mag), 0);
        chk("R1 en", int'(en), 0);
        chk("R1 oe", int'(sda_oe), 0);
        rst_n = 1'b1;
        tick(10);
        check_channels("R1 after release");

        // vector table: write, check outputs, read back
        for (int v = 0; v < NV; v++) begin
            logic [7:0] va, vd;
            int ch;
            va = VEC[v][24:17];
            vd = VEC[v][16:9];
            ch = (va == 8'hF9) ? 1 : 0;
            write_txn(va, vd, acks);
            chk("R2 write acks", int'(acks), 7);
            shadow[ch] = vd;
            chk("R3 vec src", int'(src[ch]), int'(VEC[v][8]));
            chk("R3 vec mag", int'(mag[ch*MW +: MW]), int'(VEC[v][7:1]));
            chk("R4 vec en", int'(en[ch]), int'(VEC[v][0]));
            check_channels("vec");
            read_txn(va, rd, acks);
            chk("R2 read acks", int'(acks), 7);
            chk("R5 readback", int'(rd), int'(vd));
            chk("R5 released after nack", int'(last_oe), 0);
            chk("R5 released after stop", int'(sda_oe), 0);
        end

        // R2: wrong device address, following bytes ignored
        bus_start();
        send_byte(8'hA0, a);
        chk("R2 foreign addr nack", int'(a), 0);
        send_byte(8'hF8, a);
        chk("R2 ignored mem byte", int'(a), 0);
        send_byte(8'h55, a);
        chk("R2 ignored data byte", int'(a), 0);
        bus_stop();
        check_channels("R2 ignored");

        // R6: unmapped register address
        write_txn(8'hFA, 8'h33, acks);
        chk("R6 unmapped acks", int'(acks), 7);
        check_channels("R6 discarded");
        read_txn(8'hFA, rd, acks);
        chk("R6 unmapped read", int'(rd), 0);

        // R9: pointer persists into a read-only transaction
        write_txn(8'hF9, 8'h9C, acks);
        shadow[1] = 8'h9C;
        check_channels("R9 setup");
        bus_start();
        send_byte(8'h91, a);
        chk("R9 read addr ack", int'(a), 1);
        recv_byte(1'b1, rd);
        bus_stop();
        chk("R9 persistent pointer read", int'(rd), 8'h9C);
        chk("R5 released after short read", int'(last_oe), 0);

        // R7: repeated start mid data byte
        bus_start();
        send_byte(8'h90, a);
        send_byte(8'hF8, a);
        for (int i = 0; i < 4; i++) begin
            logic m, o0, o1;
            bit_cycle(1'b1, m, o0, o1);
        end
        bus_start();
        bus_stop();
        check_channels("R7 rstart abort");

        // R7: stop mid data byte
        bus_start();
        send_byte(8'h90, a);
        send_byte(8'hF9, a);
        for (int i = 0; i < 5; i++) begin
            logic m, o0, o1;
            bit_cycle(1'b0, m, o0, o1);
        end
        bus_stop();
        check_channels("R7 stop abort");
        read_txn(8'hF9, rd, acks);
        chk("R7 reg kept", int'(rd), 8'h9C);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule